// File: doc/BRIEF.md
# Command Frame Engine

This block sits on the slave side of an 8-bit host port. It collects command words four bytes at a time, least significant byte first. The top byte of each word is an opcode. The low 24 bits are a target address or a subcommand, and the engine ORs them with the fixed base `0xBF000000` to rebuild the full target address. For reads and writes it checks that address against a fixed list of permitted windows. It then performs the access on a small internal register array that stands in for the peripherals.

Every command except the null opcode and the system-null subcommand gets a response: a 32-bit status word (`0x55` on success, `0xFF` on error) followed by a 32-bit data word, both sent low byte first. The `cmd_rdy` output rises in the same cycle the status word becomes available. It falls in the cycle after the host takes the fourth status byte, which is also the cycle the data word appears.

Both byte streams use valid/ready. An input byte is taken in a cycle where `in_valid` and `in_ready` are both high. `in_ready` stays low while a command executes or a response is pending, so the host must hold its byte until it is taken. An output byte is taken in a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_byte` and `out_valid` hold.

Top module: `cfe_engine`

## Requirements
- R1: Input bytes build a word from the low byte upward. Decoding starts only after the fourth byte of a word is taken. `in_ready` is high in reset and while the engine waits for a command or payload byte, and low whenever `out_valid` is high.
- R2: The opcode sits in bits 31..24. Values outside {0x00, 0x01, 0x02, 0x10, 0x20, 0x40} are answered with status `0xFF` and data 0, after which the engine accepts a new command.
- R3: A register access (opcode 0x01 read, 0x10 write) succeeds only if `0xBF000000 | bits[23:0]` lies inside one of these windows, bounds included: 0xBF805200–0xBF8053FF, 0xBF805800–0xBF805BFF, 0xBF809000–0xBF8091FF, 0xBF881000–0xBF881FFF, 0xBF886000–0xBF8861FF. Any other address gives status `0xFF`.
- R4: The status word is 0x00000055 on success and 0x000000FF on error. Its first byte out is therefore `0x55` or `0xFF`.
- R5: `cmd_rdy` rises in the cycle the first status byte is valid. It stays high until the fourth status byte is taken, then drops in the cycle the data word becomes valid. The data word is always sent, even after an error status.
- R6: A register read (0x01) returns the array word at index address[log2(NREG)+1:2]. A read that fails the window check returns data 0.
- R7: A register write (0x10) takes a second four-byte payload word before responding. It stores the payload only when the window check passes, and its data word is 0.
- R8: A system read (0x02) with subcommand 0x000002 returns status OK and data {16'h0, VER_MAJOR, VER_MINOR}. Any other subcommand gives status `0xFF` and data 0.
- R9: A system write (0x20) also takes a payload word. Subcommand 0x000000 flushes the engine back to idle with no response. Subcommand 0x000001 clears every array word to 0 and answers OK with data 0. Any other subcommand answers `0xFF` with data 0.
- R10: Opcode 0x00 produces no response: `cmd_rdy` and `out_valid` stay low, and the next command is decoded normally.
- R11: Opcode 0x40 (interrupt clear) answers OK with data 0 and leaves the register array unchanged.
- R12: While `out_valid` is high and `out_ready` is low, `out_byte` and `out_valid` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host offers an input byte |
| in_ready | output | 1 | Engine takes the offered byte this cycle |
| in_byte | input | 8 | Input byte, low byte of each word first |
| out_valid | output | 1 | Response byte available |
| out_ready | input | 1 | Host takes the response byte this cycle |
| out_byte | output | 8 | Response byte, low byte of each word first |
| cmd_rdy | output | 1 | Status word pending in the output buffer |

## Verification
The bench builds the engine with NREG = 4 and a version of 3.42. With only four array words, addresses in different windows, and addresses outside every window, map to the same word. This lets the bench catch a write that was rejected but still landed, by reading the same word back through an address inside a window. The small array also lets a system reset be checked against every word, and the non-default version bytes show whether they reach the correct positions of the data word. Random back-pressure on both streams checks that `out_byte` holds while stalled and that `cmd_rdy` stays high across a stalled status word.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
  localparam logic [7:0]  OP_NULL = 8'h00;
  localparam logic [7:0]  OP_RD   = 8'h01;
  localparam logic [7:0]  OP_SRD  = 8'h02;
  localparam logic [7:0]  OP_WR   = 8'h10;
  localparam logic [7:0]  OP_SWR  = 8'h20;
  localparam logic [7:0]  OP_ICLR = 8'h40;

  localparam logic [23:0] SUB_NULL  = 24'h000000;
  localparam logic [23:0] SUB_RESET = 24'h000001;
  localparam logic [23:0] SUB_VER   = 24'h000002;

  localparam logic [31:0] ST_OK   = 32'h0000_0055;
  localparam logic [31:0] ST_ERR  = 32'h0000_00FF;
  localparam logic [31:0] BASE    = 32'hBF00_0000;

  localparam int NWIN = 5;
  localparam logic [NWIN-1:0][31:0] WLO = {32'hBF88_6000, 32'hBF88_1000, 32'hBF80_9000,
                                           32'hBF80_5800, 32'hBF80_5200};
  localparam logic [NWIN-1:0][31:0] WHI = {32'hBF88_61FF, 32'hBF88_1FFF, 32'hBF80_91FF,
                                           32'hBF80_5BFF, 32'hBF80_53FF};

  typedef enum logic [2:0] {S_CMD, S_PAY, S_EXEC, S_STAT, S_DATA} fsm_e;
endpackage

// File: rtl/cfe_win_check.sv
module cfe_win_check
  import cfe_pkg::*;
(
  input  logic [31:0] addr,
  output logic        hit
);
  logic [NWIN-1:0] in_w;
  for (genvar i = 0; i < NWIN; i++) begin : g_win
    assign in_w[i] = (addr >= WLO[i]) && (addr <= WHI[i]);
  end
  assign hit = |in_w;
endmodule

// File: rtl/cfe_byte_packer.sv
module cfe_byte_packer #(
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               flush,
  input  logic               in_valid,
  input  logic [7:0]         in_byte,
  output logic               in_ready,
  output logic [BYTES*8-1:0] word,
  output logic               done
);
  localparam int CW = (BYTES > 1) ? $clog2(BYTES) : 1;
  logic [CW-1:0] cnt;

  assign in_ready = en & ~done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
      word <= '0;
    end else begin
      done <= 1'b0;
      if (flush) begin
        cnt <= '0;
      end else if (in_valid && in_ready) begin
        word[8*int'(cnt) +: 8] <= in_byte;
        if (cnt == CW'(BYTES-1)) begin
          cnt  <= '0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfe_byte_unpacker.sv
module cfe_byte_unpacker #(
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [BYTES*8-1:0] word,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_byte,
  output logic               last
);
  localparam int CW = (BYTES > 1) ? $clog2(BYTES) : 1;
  logic [BYTES*8-1:0] shreg;
  logic [CW-1:0]      cnt;
  logic               busy;

  assign out_valid = busy;
  assign out_byte  = shreg[7:0];
  assign last      = busy && out_ready && (cnt == CW'(BYTES-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
    end else if (load) begin
      shreg <= word;
      cnt   <= '0;
      busy  <= 1'b1;
    end else if (busy && out_ready) begin
      shreg <= shreg >> 8;
      if (cnt == CW'(BYTES-1)) begin
        cnt  <= '0;
        busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfe_regfile.sv
module cfe_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [NREG];

  assign rdata = mem[idx];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end
endmodule

// File: rtl/cfe_engine.sv
module cfe_engine
  import cfe_pkg::*;
#(
  parameter int          NREG      = 16,
  parameter logic [7:0]  VER_MAJOR = 8'd1,
  parameter logic [7:0]  VER_MINOR = 8'd0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_byte,
  output logic       cmd_rdy
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  fsm_e        state;
  logic [31:0] cmd_q, pay_q, resp_q;
  logic        rdy_q;

  logic        pk_en, pk_done, pk_flush;
  logic [31:0] pk_word;
  logic        up_load, up_last;
  logic [31:0] up_word;

  logic [31:0] full_addr;
  logic        hit;
  logic [31:0] rdata;

  logic [7:0]  op;
  logic [23:0] sub;
  logic [31:0] sts, dat;
  logic        do_wr, do_clr, no_resp;

  assign pk_en    = (state == S_CMD) || (state == S_PAY);
  assign pk_flush = (state == S_EXEC) && no_resp;

  cfe_byte_packer #(.BYTES(4)) u_pack (
    .clk(clk), .rst_n(rst_n), .en(pk_en), .flush(pk_flush),
    .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .word(pk_word), .done(pk_done)
  );

  assign full_addr = BASE | {8'h00, cmd_q[23:0]};

  cfe_win_check u_win (.addr(full_addr), .hit(hit));

  cfe_regfile #(.NREG(NREG), .DW(32)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .clr((state == S_EXEC) && do_clr),
    .we((state == S_EXEC) && do_wr),
    .idx(full_addr[2 +: IW]), .wdata(pay_q), .rdata(rdata)
  );

  assign op  = cmd_q[31:24];
  assign sub = cmd_q[23:0];

  always_comb begin
    sts     = ST_ERR;
    dat     = '0;
    do_wr   = 1'b0;
    do_clr  = 1'b0;
    no_resp = 1'b0;
    unique case (op)
      OP_RD: if (hit) begin
        sts = ST_OK;
        dat = rdata;
      end
      OP_WR: if (hit) begin
        sts   = ST_OK;
        do_wr = 1'b1;
      end
      OP_SRD: if (sub == SUB_VER) begin
        sts = ST_OK;
        dat = {16'h0000, VER_MAJOR, VER_MINOR};
      end
      OP_SWR: begin
        if (sub == SUB_NULL) begin
          no_resp = 1'b1;
        end else if (sub == SUB_RESET) begin
          sts    = ST_OK;
          do_clr = 1'b1;
        end
      end
      OP_ICLR: sts = ST_OK;
      default: sts = ST_ERR;
    endcase
  end

  assign up_load = ((state == S_EXEC) && !no_resp) || ((state == S_STAT) && up_last);
  assign up_word = (state == S_EXEC) ? sts : resp_q;

  cfe_byte_unpacker #(.BYTES(4)) u_unpack (
    .clk(clk), .rst_n(rst_n), .load(up_load), .word(up_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .last(up_last)
  );

  assign cmd_rdy = rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_CMD;
      cmd_q  <= '0;
      pay_q  <= '0;
      resp_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      unique case (state)
        S_CMD: if (pk_done) begin
          cmd_q <= pk_word;
          if (pk_word[31:24] == OP_NULL) state <= S_CMD;
          else if (pk_word[31:24] == OP_WR || pk_word[31:24] == OP_SWR) state <= S_PAY;
          else state <= S_EXEC;
        end
        S_PAY: if (pk_done) begin
          pay_q <= pk_word;
          state <= S_EXEC;
        end
        S_EXEC: begin
          if (no_resp) begin
            state <= S_CMD;
          end else begin
            resp_q <= dat;
            rdy_q  <= 1'b1;
            state  <= S_STAT;
          end
        end
        S_STAT: if (up_last) begin
          rdy_q <= 1'b0;
          state <= S_DATA;
        end
        S_DATA: if (up_last) state <= S_CMD;
        default: state <= S_CMD;
      endcase
    end
  end
endmodule

// File: rtl/cfe_engine_chk.sv
module cfe_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte,
  input logic       cmd_rdy
);
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

  assert_rdy_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_rdy) |-> (out_valid && (out_byte == 8'h55 || out_byte == 8'hFF)));

  assert_data_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_rdy) |-> out_valid);

  assert_no_input_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_rdy_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rdy |-> !in_ready);
endmodule

bind cfe_engine cfe_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_byte(out_byte), .cmd_rdy(cmd_rdy)
);

// File: tb/cfe_engine_tb.sv
module cfe_engine_tb;
  localparam int NREG = 4;
  localparam logic [7:0] VMAJ = 8'h03;
  localparam logic [7:0] VMIN = 8'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_byte = 8'h00;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [7:0] out_byte;
  logic cmd_rdy;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [31:0] mdl [NREG];

  always #2.5 clk = ~clk;

  cfe_engine #(.NREG(NREG), .VER_MAJOR(VMAJ), .VER_MINOR(VMIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .cmd_rdy(cmd_rdy)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [23:0] a);
    logic [31:0] f = 32'hBF00_0000 | {8'h00, a};
    return (f >= 32'hBF805200 && f <= 32'hBF8053FF) ||
           (f >= 32'hBF805800 && f <= 32'hBF805BFF) ||
           (f >= 32'hBF809000 && f <= 32'hBF8091FF) ||
           (f >= 32'hBF881000 && f <= 32'hBF881FFF) ||
           (f >= 32'hBF886000 && f <= 32'hBF8861FF);
  endfunction

  // Reference behaviour from the requirements; updates the model array.
  task automatic model(input logic [31:0] c, input logic [31:0] p,
                       output bit has_pay, output bit resp,
                       output logic [31:0] st, output logic [31:0] dt);
    logic [7:0] op = c[31:24];
    int idx = int'(c[3:2]);
    has_pay = (op == 8'h10) || (op == 8'h20);
    resp = 1'b1;
    st = 32'hFF;
    dt = 32'h0;
    case (op)
      8'h00: resp = 1'b0;
      8'h01: if (in_win(c[23:0])) begin st = 32'h55; dt = mdl[idx]; end
      8'h10: if (in_win(c[23:0])) begin st = 32'h55; mdl[idx] = p; end
      8'h02: if (c[23:0] == 24'h2) begin st = 32'h55; dt = {16'h0, VMAJ, VMIN}; end
      8'h20: begin
        if (c[23:0] == 24'h0) resp = 1'b0;
        else if (c[23:0] == 24'h1) begin
          st = 32'h55;
          for (int i = 0; i < NREG; i++) mdl[i] = 32'h0;
        end
      end
      8'h40: st = 32'h55;
      default: st = 32'hFF;
    endcase
  endtask

  task automatic send_byte(input logic [7:0] b);
    repeat ($urandom % 3) @(negedge clk);
    in_byte = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 0; i < 4; i++) send_byte(w[8*i +: 8]);
  endtask

  task automatic recv_byte(output logic [7:0] b, output logic rdy);
    repeat ($urandom % 3) @(negedge clk);
    out_ready = 1'b1;
    while (!out_valid) @(negedge clk);
    rdy = cmd_rdy;
    b = out_byte;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic xact(input logic [31:0] c, input logic [31:0] p, input string tag);
    bit hp, rs;
    logic [31:0] est, edt, w;
    logic [7:0] b;
    logic r;
    bit rdy_ok;
    model(c, p, hp, rs, est, edt);
    send_word(c);
    if (hp) send_word(p);
    if (!rs) begin
      repeat (8) @(negedge clk);
      chk(!out_valid && !cmd_rdy && in_ready, {tag, " R10 R9 no response"},
          {29'h0, out_valid, cmd_rdy, in_ready}, 32'h1);
      return;
    end
    rdy_ok = 1'b1;
    for (int i = 0; i < 4; i++) begin
      recv_byte(b, r);
      w[8*i +: 8] = b;
      if (!r) rdy_ok = 1'b0;
    end
    chk(rdy_ok, {tag, " R5 cmd_rdy high over status"}, {31'h0, rdy_ok}, 32'h1);
    chk(!cmd_rdy && out_valid, {tag, " R5 ready drop with data"}, {30'h0, cmd_rdy, out_valid}, 32'h1);
    chk(w == est, {tag, " R4 status"}, w, est);
    for (int i = 0; i < 4; i++) begin
      recv_byte(b, r);
      w[8*i +: 8] = b;
    end
    chk(w == edt, {tag, " data"}, w, edt);
  endtask

  task automatic hold_check();
    logic [7:0] b0;
    send_word(32'h0200_0002);
    while (!out_valid) @(negedge clk);
    b0 = out_byte;
    repeat (5) @(negedge clk);
    chk(out_valid && out_byte == b0 && cmd_rdy, "R12 hold under stall", {24'h0, out_byte}, {24'h0, b0});
    for (int i = 0; i < 8; i++) begin
      logic [7:0] b;
      logic r;
      recv_byte(b, r);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NREG; i++) mdl[i] = 32'h0;
    repeat (4) @(negedge clk);
    chk(!cmd_rdy && !out_valid && in_ready, "R1 reset state",
        {29'h0, cmd_rdy, out_valid, in_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    xact(32'h1080_5204, 32'hA1B2_C3D4, "R7 R1 write in window");
    xact(32'h0180_5204, 32'h0, "R6 R1 read back");
    xact(32'h1080_5404, 32'h1111_2222, "R7 R3 write outside");
    xact(32'h0180_5204, 32'h0, "R7 rejected write left word");
    xact(32'h0180_53FF, 32'h0, "R3 upper bound");
    xact(32'h0180_5400, 32'h0, "R3 above bound");
    xact(32'h0180_51FF, 32'h0, "R3 below bound R6");
    xact(32'h0188_1000, 32'h0, "R3 high bank low bound");
    xact(32'h0000_1234, 32'h0, "R10 null opcode");
    xact(32'h0200_0002, 32'h0, "R8 version");
    xact(32'h0200_0003, 32'h0, "R8 bad subcommand");
    xact(32'h7F80_5204, 32'h0, "R2 unknown opcode");
    xact(32'h4000_0083, 32'h0, "R11 irq clear");
    xact(32'h0180_5204, 32'h0, "R11 array intact");
    xact(32'h2000_0000, 32'hDEAD_BEEF, "R9 system null");
    xact(32'h2000_0007, 32'h0, "R9 bad system write");
    xact(32'h1088_6008, 32'h5A5A_0001, "R7 write bank two");
    xact(32'h2000_0001, 32'h0, "R9 system reset");
    xact(32'h0188_6008, 32'h0, "R9 cleared word");
    hold_check();

    for (int n = 0; n < 150; n++) begin
      logic [31:0] c, p;
      logic [23:0] a;
      logic [7:0] ops [8] = '{8'h01, 8'h10, 8'h01, 8'h10, 8'h02, 8'h40, 8'h00, 8'h33};
      case ($urandom % 3)
        0: a = $urandom;
        1: a = 24'h805200 + 24'(($urandom % 24'h400) & 24'hFFC);
        default: begin
          case ($urandom % 4)
            0: a = 24'h809000 + 24'($urandom % 24'h200);
            1: a = 24'h881000 + 24'($urandom % 24'h1000);
            2: a = 24'h886000 + 24'($urandom % 24'h200);
            default: a = 24'h805800 + 24'($urandom % 24'h400);
          endcase
        end
      endcase
      c = {ops[$urandom % 8], a};
      if (c[31:24] == 8'h02 && ($urandom % 2) == 0) c[23:0] = 24'h2;
      p = $urandom;
      xact(c, p, "R2 R3 R6 R7 random");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule